// File: doc/BRIEF.md
# 8b/10b Line Encoder with Debug Output Modes

This block turns a stream of octets, each tagged as data or control, into 10-bit line characters. The line stays DC balanced because a running disparity is carried from one character to the next. Each input octet is split into a 5-bit and a 3-bit part, and each part goes through its own sub-block code. The running disparity selects between the two complementary forms of any code that is not balanced. Control octets are accepted only for the five alignment characters that a high-speed converter link uses: K28.0, K28.3, K28.4, K28.5 and K28.7.

Three static configuration inputs help with bring-up of the digital front end. The bypass input sends the raw octet out instead of the encoded character. The invert input complements every output bit. The mirror input reverses the bit order of the output character. Every character leaves one clock after it enters, whatever the mode. Serialization happens downstream of this block.

Top module: `line_code_8b10b`

## Requirements
- R1: After reset, out_valid, out_kerr and out_char are all zero and the running disparity is negative, so data octet 0x00 as the first character encodes to 10'h274.
- R2: With all modes off, a data octet HGFEDCBA (in_octet[7:0], A = bit 0) is encoded with the standard 8b/10b tables. The output is out_char[9:0] = {a,b,c,d,e,i,f,g,h,j}, with a at bit 9.
- R3: Every encoded character has 4, 5 or 6 ones. The running disparity changes after a character only when the character does not hold exactly five ones.
- R4: Control octets 0x1C, 0x7C, 0x9C, 0xBC and 0xFC (in_ctrl = 1) give K28.0, K28.3, K28.4, K28.5 and K28.7. K28.5 is 10'h0FA from negative disparity and 10'h305 from positive disparity.
- R5: A control flag on any other octet sends K28.5 instead and raises out_kerr together with that character. Outside bypass, out_kerr is low for every other character.
- R6: With cfg_bypass high, out_char is {2'b00, in_octet}, out_kerr stays low and the running disparity does not change. The next encoded character after bypass ends uses the disparity that was in force before bypass started.
- R7: With cfg_invert high, every bit of the character (encoded, or raw in bypass) is complemented.
- R8: With cfg_mirror high, bit n of the character moves to bit 9-n. This is applied after inversion when both are set.
- R9: out_valid is in_valid delayed by exactly one clock in every mode. A cycle without in_valid produces no output and leaves the running disparity unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_bypass | input | 1 | Static: send the raw octet in place of the encoded character |
| cfg_invert | input | 1 | Static: complement all output bits |
| cfg_mirror | input | 1 | Static: reverse the output bit order |
| in_octet | input | 8 | Octet to encode |
| in_ctrl | input | 1 | Octet is a control character |
| in_valid | input | 1 | in_octet and in_ctrl are valid this cycle |
| out_char | output | 10 | Line character |
| out_valid | output | 1 | out_char is valid |
| out_kerr | output | 1 | The control code in the matching input was not allowed; K28.5 was sent |

## Verification
Each result (character, error flag and valid) is due on the first rising edge after the input is presented. The driver drives inputs on the falling edge, tags each expected item with the cycle count plus one, and pushes it into the queue. The monitor compares on the next falling edge. At that edge it flags a missing out_valid, an out_valid that was not expected, or a due item that is still waiting. Disparity is checked indirectly: the bench model carries its own running disparity across gaps, bypass stretches and resets, so a wrong disparity update shows up as a mismatch on a later character.

// File: rtl/lc8b10b_pkg.sv
package lc8b10b_pkg;
  localparam int OCTET_W = 8;
  localparam int CHAR_W  = 10;
  localparam int SUB6_W  = 6;
  localparam int SUB4_W  = 4;
  localparam logic [4:0] K28_LOW = 5'd28;
  localparam logic [OCTET_W-1:0] K28_5_OCTET = 8'hBC;
endpackage

// File: rtl/lc_kfilter.sv
module lc_kfilter
  import lc8b10b_pkg::*;
(
  input  logic [OCTET_W-1:0] octet_i,
  input  logic               k_i,
  output logic [OCTET_W-1:0] octet_o,
  output logic               bad_o
);
  logic legal;

  always_comb begin
    legal = 1'b0;
    if (octet_i[4:0] == K28_LOW) begin
      case (octet_i[7:5])
        3'd0, 3'd3, 3'd4, 3'd5, 3'd7: legal = 1'b1;
        default:                      legal = 1'b0;
      endcase
    end
    bad_o   = k_i && !legal;
    octet_o = bad_o ? K28_5_OCTET : octet_i;
  end
endmodule

// File: rtl/lc_sub6_enc.sv
module lc_sub6_enc
  import lc8b10b_pkg::*;
(
  input  logic [4:0]        x_i,
  input  logic              k_i,
  input  logic              rd_i,
  output logic [SUB6_W-1:0] code_o,
  output logic              rd_o
);
  logic [SUB6_W-1:0] base;
  logic              unbal;
  logic              compl;

  // base holds the form used from negative disparity, bits abcdei
  always_comb begin
    unique case (x_i)
      5'd0:  base = 6'b100111;
      5'd1:  base = 6'b011101;
      5'd2:  base = 6'b101101;
      5'd3:  base = 6'b110001;
      5'd4:  base = 6'b110101;
      5'd5:  base = 6'b101001;
      5'd6:  base = 6'b011001;
      5'd7:  base = 6'b111000;
      5'd8:  base = 6'b111001;
      5'd9:  base = 6'b100101;
      5'd10: base = 6'b010101;
      5'd11: base = 6'b110100;
      5'd12: base = 6'b001101;
      5'd13: base = 6'b101100;
      5'd14: base = 6'b011100;
      5'd15: base = 6'b010111;
      5'd16: base = 6'b011011;
      5'd17: base = 6'b100011;
      5'd18: base = 6'b010011;
      5'd19: base = 6'b110010;
      5'd20: base = 6'b001011;
      5'd21: base = 6'b101010;
      5'd22: base = 6'b011010;
      5'd23: base = 6'b111010;
      5'd24: base = 6'b110011;
      5'd25: base = 6'b100110;
      5'd26: base = 6'b010110;
      5'd27: base = 6'b110110;
      5'd28: base = 6'b001110;
      5'd29: base = 6'b101110;
      5'd30: base = 6'b011110;
      default: base = 6'b101011;
    endcase
    if (k_i) base = 6'b001111;
    unbal  = ($countones(base) != 3);
    compl  = unbal || ((x_i == 5'd7) && !k_i);
    code_o = (rd_i && compl) ? ~base : base;
    rd_o   = unbal ? ~rd_i : rd_i;
  end
endmodule

// File: rtl/lc_sub4_enc.sv
module lc_sub4_enc
  import lc8b10b_pkg::*;
(
  input  logic [2:0]        y_i,
  input  logic [4:0]        x_i,
  input  logic              k_i,
  input  logic              rd_i,
  output logic [SUB4_W-1:0] code_o,
  output logic              rd_o
);
  logic [SUB4_W-1:0] base;
  logic [SUB4_W-1:0] pos_form;
  logic              alt7;
  logic              compl;

  always_comb begin
    alt7 = k_i
        || (!rd_i && (x_i == 5'd17 || x_i == 5'd18 || x_i == 5'd20))
        || ( rd_i && (x_i == 5'd11 || x_i == 5'd13 || x_i == 5'd14));
    unique case (y_i)
      3'd0:    base = 4'b1011;
      3'd1:    base = 4'b1001;
      3'd2:    base = 4'b0101;
      3'd3:    base = 4'b1100;
      3'd4:    base = 4'b1101;
      3'd5:    base = 4'b1010;
      3'd6:    base = 4'b0110;
      default: base = alt7 ? 4'b0111 : 4'b1110;
    endcase
    compl    = (y_i == 3'd0) || (y_i == 3'd3) || (y_i == 3'd4) || (y_i == 3'd7);
    pos_form = compl ? ~base : base;
    if (k_i)
      code_o = rd_i ? pos_form : ~pos_form;
    else
      code_o = rd_i ? pos_form : base;
    rd_o = ($countones(code_o) != 2) ? ~rd_i : rd_i;
  end
endmodule

// File: rtl/lc_test_mux.sv
module lc_test_mux #(
  parameter int W     = 10,
  parameter int RAW_W = 8
) (
  input  logic [W-1:0]     enc_i,
  input  logic [RAW_W-1:0] raw_i,
  input  logic             bypass_i,
  input  logic             invert_i,
  input  logic             mirror_i,
  output logic [W-1:0]     char_o
);
  localparam int PAD = W - RAW_W;

  logic [W-1:0] sel;
  logic [W-1:0] inv;
  logic [W-1:0] rev;

  always_comb begin
    sel = bypass_i ? {{PAD{1'b0}}, raw_i} : enc_i;
    inv = invert_i ? ~sel : sel;
  end

  for (genvar g = 0; g < W; g++) begin : g_rev
    assign rev[g] = inv[W-1-g];
  end

  assign char_o = mirror_i ? rev : inv;
endmodule

// File: rtl/line_code_8b10b.sv
module line_code_8b10b
  import lc8b10b_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               cfg_bypass,
  input  logic               cfg_invert,
  input  logic               cfg_mirror,
  input  logic [OCTET_W-1:0] in_octet,
  input  logic               in_ctrl,
  input  logic               in_valid,
  output logic [CHAR_W-1:0]  out_char,
  output logic               out_valid,
  output logic               out_kerr
);
  logic [OCTET_W-1:0] oct_f;
  logic               bad;
  logic [SUB6_W-1:0]  c6;
  logic [SUB4_W-1:0]  c4;
  logic               rd_q;
  logic               rd_mid;
  logic               rd_next;
  logic [CHAR_W-1:0]  muxed;

  lc_kfilter u_kf (
    .octet_i(in_octet), .k_i(in_ctrl), .octet_o(oct_f), .bad_o(bad)
  );

  lc_sub6_enc u_s6 (
    .x_i(oct_f[4:0]), .k_i(in_ctrl), .rd_i(rd_q), .code_o(c6), .rd_o(rd_mid)
  );

  lc_sub4_enc u_s4 (
    .y_i(oct_f[7:5]), .x_i(oct_f[4:0]), .k_i(in_ctrl), .rd_i(rd_mid),
    .code_o(c4), .rd_o(rd_next)
  );

  lc_test_mux #(.W(CHAR_W), .RAW_W(OCTET_W)) u_mux (
    .enc_i({c6, c4}), .raw_i(in_octet), .bypass_i(cfg_bypass),
    .invert_i(cfg_invert), .mirror_i(cfg_mirror), .char_o(muxed)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q      <= 1'b0;
      out_char  <= '0;
      out_valid <= 1'b0;
      out_kerr  <= 1'b0;
    end else begin
      out_valid <= in_valid;
      out_kerr  <= in_valid && bad && !cfg_bypass;
      if (in_valid) begin
        out_char <= muxed;
        if (!cfg_bypass) rd_q <= rd_next;
      end
    end
  end

  // R9: fixed one-cycle latency, idle cycles are silent
  p_valid_lat_r9: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  p_idle_r9: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  p_rd_idle_r9: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(rd_q));

  // R5: the error flag only travels with a character
  p_kerr_valid_r5: assert property (@(posedge clk) disable iff (rst)
    out_kerr |-> out_valid);

  // R3: balance and disparity bookkeeping
  p_balance_r3: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !cfg_bypass) |->
      ($countones(out_char) >= 4 && $countones(out_char) <= 6));
  p_rd_flip_r3: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !cfg_bypass) |->
      ((rd_q != $past(rd_q)) == ($countones(out_char) != 5)));

  // R6: bypass leaves disparity alone and pads the top bits with zero
  p_rd_bypass_r6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && cfg_bypass) |=> $stable(rd_q));
  p_bypass_pad_r6: assert property (@(posedge clk) disable iff (rst)
    (out_valid && cfg_bypass && !cfg_invert && !cfg_mirror) |->
      (out_char[9:8] == 2'b00));
endmodule

// File: tb/line_code_8b10b_tb_top.sv
`timescale 1ns/1ps
module line_code_8b10b_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_bypass = 1'b0, cfg_invert = 1'b0, cfg_mirror = 1'b0;
  logic [7:0] in_octet = 8'h00;
  logic       in_ctrl = 1'b0, in_valid = 1'b0;
  logic [9:0] out_char;
  logic       out_valid, out_kerr;

  always #2 clk = ~clk;

  line_code_8b10b dut_i (
    .clk(clk), .rst(rst), .cfg_bypass(cfg_bypass), .cfg_invert(cfg_invert),
    .cfg_mirror(cfg_mirror), .in_octet(in_octet), .in_ctrl(in_ctrl),
    .in_valid(in_valid), .out_char(out_char), .out_valid(out_valid),
    .out_kerr(out_kerr)
  );

  typedef struct {
    logic [9:0] ch;
    logic       err;
    int         due;
    string      req;
  } exp_t;

  exp_t q[$];
  int   cyc = 0;
  int   n_cmp = 0;
  int   n_bad = 0;
  logic m_rd = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic report(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
    n_bad++;
    $display("FAIL %s %s: actual %0h expected %0h (cycle %0d)", req, what, act, exp, cyc);
  endtask

  // standard negative-disparity forms
  function automatic logic [5:0] six_neg(input logic [4:0] x);
    case (x)
      0: return 6'b100111;  1: return 6'b011101;  2: return 6'b101101;
      3: return 6'b110001;  4: return 6'b110101;  5: return 6'b101001;
      6: return 6'b011001;  7: return 6'b111000;  8: return 6'b111001;
      9: return 6'b100101; 10: return 6'b010101; 11: return 6'b110100;
     12: return 6'b001101; 13: return 6'b101100; 14: return 6'b011100;
     15: return 6'b010111; 16: return 6'b011011; 17: return 6'b100011;
     18: return 6'b010011; 19: return 6'b110010; 20: return 6'b001011;
     21: return 6'b101010; 22: return 6'b011010; 23: return 6'b111010;
     24: return 6'b110011; 25: return 6'b100110; 26: return 6'b010110;
     27: return 6'b110110; 28: return 6'b001110; 29: return 6'b101110;
     30: return 6'b011110; default: return 6'b101011;
    endcase
  endfunction

  function automatic logic [3:0] four_neg(input logic [2:0] y);
    case (y)
      0: return 4'b1011; 1: return 4'b1001; 2: return 4'b0101; 3: return 4'b1100;
      4: return 4'b1101; 5: return 4'b1010; 6: return 4'b0110; default: return 4'b1110;
    endcase
  endfunction

  function automatic logic [9:0] ref_enc(input logic [7:0] b_in, input logic k,
                                         input logic rd_in, output logic rd_out,
                                         output logic err);
    logic [7:0] b;
    logic [5:0] s6;
    logic [3:0] s4;
    logic [9:0] neg10;
    logic [9:0] ch;
    logic       rdm;
    logic [4:0] x;
    b   = b_in;
    err = 1'b0;
    if (k && !(b inside {8'h1C, 8'h7C, 8'h9C, 8'hBC, 8'hFC})) begin
      err = 1'b1;
      b   = 8'hBC;
    end
    x = b[4:0];
    if (k) begin
      case (b[7:5])
        3'd0:    neg10 = 10'b0011110100;
        3'd3:    neg10 = 10'b0011110011;
        3'd4:    neg10 = 10'b0011110010;
        3'd5:    neg10 = 10'b0011111010;
        default: neg10 = 10'b0011111000;
      endcase
      ch = rd_in ? ~neg10 : neg10;
    end else begin
      s6 = six_neg(x);
      if (rd_in && ($countones(s6) != 3 || x == 5'd7)) s6 = ~s6;
      rdm = ($countones(s6) == 3) ? rd_in : ~rd_in;
      if (b[7:5] == 3'd7) begin
        if ((!rdm && (x == 17 || x == 18 || x == 20)) || (rdm && (x == 11 || x == 13 || x == 14)))
          s4 = rdm ? 4'b1000 : 4'b0111;
        else
          s4 = rdm ? 4'b0001 : 4'b1110;
      end else begin
        s4 = four_neg(b[7:5]);
        if (rdm && ($countones(s4) != 2 || b[7:5] == 3'd3)) s4 = ~s4;
      end
      ch = {s6, s4};
    end
    rd_out = ($countones(ch) == 5) ? rd_in : ~rd_in;
    return ch;
  endfunction

  function automatic logic [9:0] finish_modes(input logic [9:0] c);
    logic [9:0] r;
    r = cfg_invert ? ~c : c;
    if (cfg_mirror) begin
      logic [9:0] t;
      for (int i = 0; i < 10; i++) t[i] = r[9-i];
      r = t;
    end
    return r;
  endfunction

  task automatic push_drive(input logic [7:0] b, input logic k,
                            input logic [9:0] c, input logic er, input string req);
    exp_t e;
    @(negedge clk);
    in_octet = b;
    in_ctrl  = k;
    in_valid = 1'b1;
    e.ch = c; e.err = er; e.due = cyc + 1; e.req = req;
    q.push_back(e);
  endtask

  task automatic send(input logic [7:0] b, input logic k, input string req);
    logic [9:0] c;
    logic       er;
    logic       nrd;
    if (cfg_bypass) begin
      c  = {2'b00, b};
      er = 1'b0;
    end else begin
      c    = ref_enc(b, k, m_rd, nrd, er);
      m_rd = nrd;
    end
    push_drive(b, k, finish_modes(c), er, req);
  endtask

  task automatic send_lit(input logic [7:0] b, input logic k,
                          input logic [9:0] lit, input string req);
    logic er;
    logic nrd;
    logic [9:0] unused_c;
    unused_c = ref_enc(b, k, m_rd, nrd, er);
    m_rd = nrd;
    push_drive(b, k, lit, er, req);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_ctrl  = 1'b0;
    end
  endtask

  task automatic drain();
    idle(3);
    n_cmp++;
    if (q.size() != 0) report("R9", "items still pending", q.size(), 0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    in_valid = 1'b0;
    idle(3);
    rst  = 1'b0;
    m_rd = 1'b0;
    @(negedge clk);
    n_cmp += 3;
    if (out_valid !== 1'b0) report("R1", "out_valid after reset", out_valid, 0);
    if (out_kerr  !== 1'b0) report("R1", "out_kerr after reset", out_kerr, 0);
    if (out_char  !== 10'h0) report("R1", "out_char after reset", out_char, 0);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (!rst) begin
      if (q.size() > 0 && q[0].due < cyc) begin
        n_cmp++;
        report(q[0].req, "R9 result late", 0, q[0].ch);
        void'(q.pop_front());
      end
      if (q.size() > 0 && q[0].due == cyc) begin
        n_cmp++;
        if (out_valid !== 1'b1)
          report(q[0].req, "R9 out_valid missing", out_valid, 1);
        else if (out_char !== q[0].ch || out_kerr !== q[0].err)
          report(q[0].req, "char/kerr", {out_kerr, out_char}, {q[0].err, q[0].ch});
        if (out_valid === 1'b1 && !cfg_bypass) begin
          n_cmp++;
          if ($countones(out_char) < 4 || $countones(out_char) > 6)
            report("R3", "ones count", $countones(out_char), 5);
        end
        void'(q.pop_front());
      end else if (out_valid === 1'b1) begin
        n_cmp++;
        report("R9", "unexpected out_valid", 1, 0);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    do_reset();
    // R1 first character from negative disparity
    send_lit(8'h00, 1'b0, 10'h274, "R1");
    // R4 K28.5 from both disparities
    send_lit(8'hBC, 1'b1, 10'h0FA, "R4");
    send_lit(8'hBC, 1'b1, 10'h305, "R4");
    idle(2);
    // R2 every data octet, with occasional gaps (R9)
    for (int i = 0; i < 256; i++) begin
      send(i[7:0], 1'b0, "R2");
      if (i % 37 == 36) idle(1);
    end
    // R4 legal control codes, each twice so both disparities appear
    for (int r = 0; r < 2; r++) begin
      send(8'h1C, 1'b1, "R4"); send(8'h7C, 1'b1, "R4"); send(8'h9C, 1'b1, "R4");
      send(8'hBC, 1'b1, "R4"); send(8'hFC, 1'b1, "R4");
    end
    // R3 mixed pattern
    for (int i = 0; i < 200; i++) send(8'((i * 37 + 11) & 255), 1'b0, "R3");
    // R5 illegal control codes
    send(8'h00, 1'b1, "R5"); send(8'h3C, 1'b1, "R5"); send(8'hFB, 1'b1, "R5");
    send(8'h55, 1'b0, "R5"); send(8'h1D, 1'b1, "R5"); send(8'hDC, 1'b1, "R5");
    drain();
    // R6 bypass: raw octets, no error, disparity frozen
    send(8'hBC, 1'b1, "R4");
    drain();
    cfg_bypass = 1'b1;
    send(8'hA5, 1'b0, "R6"); send(8'hFF, 1'b0, "R6"); send(8'h3C, 1'b1, "R6");
    send(8'h00, 1'b1, "R6"); send(8'hBC, 1'b1, "R6");
    drain();
    cfg_bypass = 1'b0;
    send(8'hBC, 1'b1, "R6"); send(8'h07, 1'b0, "R6"); send(8'hF1, 1'b0, "R6");
    drain();
    // R7 invert
    cfg_invert = 1'b1;
    for (int i = 0; i < 20; i++) send(8'((i * 53 + 3) & 255), 1'b0, "R7");
    send(8'hBC, 1'b1, "R7");
    drain();
    // R8 mirror, then mirror with invert
    cfg_invert = 1'b0; cfg_mirror = 1'b1;
    for (int i = 0; i < 20; i++) send(8'((i * 29 + 7) & 255), 1'b0, "R8");
    send(8'h7C, 1'b1, "R8");
    drain();
    cfg_invert = 1'b1;
    for (int i = 0; i < 10; i++) send(8'((i * 71 + 5) & 255), 1'b0, "R8");
    drain();
    // R7 all three modes with bypass
    cfg_bypass = 1'b1;
    send(8'h81, 1'b0, "R7"); send(8'h0F, 1'b0, "R7");
    drain();
    cfg_bypass = 1'b0; cfg_invert = 1'b0; cfg_mirror = 1'b0;
    // R1 reset restores negative disparity
    do_reset();
    send_lit(8'hBC, 1'b1, 10'h0FA, "R1");
    drain();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule